// File: doc/BRIEF.md
# USB Host Frame Interval Timer

This block keeps frame timing for a USB host controller. A 14-bit down-counter holds the number of bit times left in the current frame. Each bit-time strobe lowers the counter by one. When the counter is at zero, the next strobe reloads it from the frame interval input. On that same boundary the block advances a 16-bit frame number, copies the interval's toggle bit into a frame toggle flag, and raises a one-cycle start-of-frame pulse.

The count runs only while the `operational` level input is high. On the cycle where that input rises, the counter is loaded directly from the interval value. After that, a change to the interval takes effect only at the next frame boundary. The toggle flag changes only when a frame ends, so software can compare it with the toggle it wrote and tell when its new interval has been applied.

A small command-code port gives read-back. The read data is combinational from the code that is presented.

Top module: `usb_frame_timer`

## Requirements
- R1: While operational, and not on the entry cycle, a `bit_tick` with a non-zero count lowers `remaining` by one in the next cycle.
- R2: While operational, a `bit_tick` with `remaining` equal to zero loads `fi_value` as sampled on that edge. A change to `fi_value` in the middle of a frame does not change the length of that frame.
- R3: On every reload of R2, `frame_toggle` takes the value of `fi_toggle` sampled on that edge. At all other times it keeps its value.
- R4: In the first cycle that `operational` is high after being low (or after reset), `remaining` is loaded from `fi_value`. The frame number does not advance and `sof` does not fire.
- R5: On every reload of R2, `frame_num` increases by one, modulo 65536. 65535 wraps to 0.
- R6: `sof` is high for exactly the one cycle after each reload of R2, and is low otherwise.
- R7: While `operational` is low, `remaining`, `frame_num` and `frame_toggle` hold, and `sof` stays low.
- R8: Read code 0x0E with `cmd_wr` low returns `frame_toggle` in bit 31, zeros in bits 30..14 and `remaining` in bits 13..0.
- R9: Read code 0x0F with `cmd_wr` low returns `frame_num` in bits 15..0 and zeros in bits 31..16.
- R10: Write code 0x8F has no effect, because the frame number is read-only. Any cycle with `cmd_wr` high reads 0, and any other code reads 0.
- R11: Synchronous active-high `rst` clears `remaining`, `frame_toggle`, `frame_num` and `sof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per USB bit time |
| fi_value | input | 14 | Frame interval in bit times |
| fi_toggle | input | 1 | Toggle bit that goes with the frame interval |
| operational | input | 1 | High while the controller is in the operational state |
| cmd_code | input | 8 | Command code for register access |
| cmd_wr | input | 1 | High when the command is a write |
| remaining | output | 14 | Bit times left in the current frame |
| frame_toggle | output | 1 | Toggle captured at the last reload |
| frame_num | output | 16 | Frame number |
| sof | output | 1 | One-cycle start-of-frame pulse |
| rd_data | output | 32 | Read data for `cmd_code` |

## Verification
A wrong count shows up on `remaining` one cycle after the strobe that caused it. A wrong reload decision also shifts every later `sof` and frame-number step, so an error in frame length becomes a persistent offset between the design and the model. A missed toggle capture or a wrong frame-number step shows on `frame_toggle` or `frame_num` in the cycle after the boundary. A decode fault shows on `rd_data` in the same cycle the code is presented. The outputs are compared with the model on every clock, so the first wrong cycle is reported.

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
  parameter int CNT_W   = 14,
  parameter int FN_W    = 16,
  parameter int DATA_W  = 32,
  parameter logic [7:0] CODE_REM = 8'h0E,
  parameter logic [7:0] CODE_FN  = 8'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic [CNT_W-1:0]  fi_value,
  input  logic              fi_toggle,
  input  logic              operational,
  input  logic [7:0]        cmd_code,
  input  logic              cmd_wr,
  output logic [CNT_W-1:0]  remaining,
  output logic              frame_toggle,
  output logic [FN_W-1:0]   frame_num,
  output logic              sof,
  output logic [DATA_W-1:0] rd_data
);

  localparam int REM_PAD = DATA_W - CNT_W - 1;
  localparam int FN_PAD  = DATA_W - FN_W;

  logic op_q;
  logic entry;
  logic reload;

  assign entry  = operational & ~op_q;
  assign reload = operational & ~entry & bit_tick & (remaining == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q         <= 1'b0;
      remaining    <= '0;
      frame_toggle <= 1'b0;
      frame_num    <= '0;
      sof          <= 1'b0;
    end else begin
      op_q <= operational;
      sof  <= reload;
      if (entry) begin
        remaining <= fi_value;
      end else if (reload) begin
        remaining    <= fi_value;
        frame_toggle <= fi_toggle;
        frame_num    <= frame_num + 1'b1;
      end else if (operational && bit_tick) begin
        remaining <= remaining - 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (!cmd_wr) begin
      if (cmd_code == CODE_REM)
        rd_data = {frame_toggle, {REM_PAD{1'b0}}, remaining};
      else if (cmd_code == CODE_FN)
        rd_data = {{FN_PAD{1'b0}}, frame_num};
    end
  end

endmodule

module usb_frame_timer_chk #(
  parameter int CNT_W   = 14,
  parameter int FN_W    = 16,
  parameter int DATA_W  = 32,
  parameter logic [7:0] CODE_REM = 8'h0E,
  parameter logic [7:0] CODE_FN  = 8'h0F
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_tick,
  input logic [CNT_W-1:0]  fi_value,
  input logic              fi_toggle,
  input logic              operational,
  input logic [7:0]        cmd_code,
  input logic              cmd_wr,
  input logic [CNT_W-1:0]  remaining,
  input logic              frame_toggle,
  input logic [FN_W-1:0]   frame_num,
  input logic              sof,
  input logic [DATA_W-1:0] rd_data,
  input logic              op_q
);

  logic at_zero_tick;
  assign at_zero_tick = operational && op_q && bit_tick && remaining == '0;

  // R1
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    operational && op_q && bit_tick && remaining != '0 |=> remaining == $past(remaining) - 1'b1);

  // R2
  reload_val_chk: assert property (@(posedge clk) disable iff (rst)
    at_zero_tick |=> remaining == $past(fi_value));

  // R3
  toggle_cap_chk: assert property (@(posedge clk) disable iff (rst)
    at_zero_tick |=> frame_toggle == $past(fi_toggle));

  // R4
  entry_load_chk: assert property (@(posedge clk) disable iff (rst)
    operational && !op_q |=> remaining == $past(fi_value) && frame_num == $past(frame_num) && !sof);

  // R5
  fn_step_chk: assert property (@(posedge clk) disable iff (rst)
    at_zero_tick |=> frame_num == $past(frame_num) + 1'b1);

  // R6
  sof_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sof |=> !sof || $past(at_zero_tick));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !operational |=> $stable(remaining) && $stable(frame_num) && $stable(frame_toggle) && !sof);

  always_comb begin
    if (!rst && !cmd_wr && cmd_code == CODE_REM) begin
      // R8
      rem_pad_chk: assert (rd_data[DATA_W-2:CNT_W] == '0);
    end
    if (!rst && !cmd_wr && cmd_code == CODE_FN) begin
      // R9
      fn_pad_chk: assert (rd_data[DATA_W-1:FN_W] == '0);
    end
    if (!rst && cmd_wr) begin
      // R10
      wr_zero_chk: assert (rd_data == '0);
    end
  end

endmodule

bind usb_frame_timer usb_frame_timer_chk #(
  .CNT_W(CNT_W), .FN_W(FN_W), .DATA_W(DATA_W), .CODE_REM(CODE_REM), .CODE_FN(CODE_FN)
) i_chk (.*);

// File: tb/test_usb_frame_timer.sv
module test_usb_frame_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_tick = 1'b0;
  logic [13:0] fi_value = 14'd5;
  logic        fi_toggle = 1'b0;
  logic        operational = 1'b0;
  logic [7:0]  cmd_code = 8'h0E;
  logic        cmd_wr = 1'b0;
  logic [13:0] remaining;
  logic        frame_toggle;
  logic [15:0] frame_num;
  logic        sof;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_rem = 0, m_tog = 0, m_fn = 0, m_sof = 0, m_prev = 0;
  bit m_reload_seen = 0;

  always #2 clk = ~clk;

  usb_frame_timer i_usb_frame_timer (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .fi_value(fi_value),
    .fi_toggle(fi_toggle), .operational(operational), .cmd_code(cmd_code),
    .cmd_wr(cmd_wr), .remaining(remaining), .frame_toggle(frame_toggle),
    .frame_num(frame_num), .sof(sof), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  always @(posedge clk) begin
    if (rst) begin
      m_rem = 0; m_tog = 0; m_fn = 0; m_sof = 0; m_prev = 0;
    end else begin
      m_sof = 0;
      if (operational && !m_prev) begin
        m_rem = fi_value;
      end else if (operational && bit_tick) begin
        if (m_rem == 0) begin
          m_rem = fi_value;
          m_tog = fi_toggle;
          m_fn = (m_fn + 1) % 65536;
          m_sof = 1;
          m_reload_seen = 1;
        end else begin
          m_rem = m_rem - 1;
        end
      end
      m_prev = operational;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      longint exp_rd;
      check(remaining == m_rem[13:0], "R1/R2/R4/R7 remaining", remaining, m_rem);
      check(frame_toggle == m_tog[0], "R3 toggle", frame_toggle, m_tog);
      check(frame_num == m_fn[15:0], "R5 frame number", frame_num, m_fn);
      check(sof == m_sof[0], "R6 sof", sof, m_sof);
      if (cmd_wr) exp_rd = 0;
      else if (cmd_code == 8'h0E) exp_rd = (longint'(m_tog) << 31) | m_rem;
      else if (cmd_code == 8'h0F) exp_rd = m_fn;
      else exp_rd = 0;
      check(rd_data == exp_rd[31:0], "R8/R9/R10 read data", rd_data, exp_rd);
    end
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic step(input bit tick);
    @(posedge clk); #1;
    bit_tick = tick;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state, with the outputs sampled while reset is still applied
    check(remaining == 0 && frame_num == 0 && frame_toggle == 0 && sof == 0,
          "R11 reset", {remaining, frame_num, frame_toggle, sof}, 0);
    rst = 1'b0;
    // R7 idle with ticks
    for (int i = 0; i < 6; i++) step(1);
    operational = 1'b1;                 // R4 entry
    fi_value = 14'd5; fi_toggle = 1'b1;
    for (int i = 0; i < 30; i++) begin
      step(1);
      cmd_code = (i % 4 == 0) ? 8'h0E : (i % 4 == 1) ? 8'h0F : (i % 4 == 2) ? 8'h8F : 8'h33;
      cmd_wr = (i % 4 == 2);
    end
    cmd_wr = 1'b0;
    // sparse ticks, mid-frame interval change (R2) and toggle change (R3)
    for (int i = 0; i < 60; i++) begin
      step(i % 3 == 0);
      if (i == 10) begin fi_value = 14'd9; fi_toggle = 1'b0; end
      cmd_code = i[0] ? 8'h0F : 8'h0E;
    end
    // R7 leave and hold, then R4 re-entry
    operational = 1'b0;
    for (int i = 0; i < 12; i++) step(1);
    fi_value = 14'd3;
    operational = 1'b1;
    for (int i = 0; i < 20; i++) step(1);
    // R10 repeated writes to the frame number code
    cmd_code = 8'h8F; cmd_wr = 1'b1;
    for (int i = 0; i < 10; i++) step(1);
    cmd_wr = 1'b0; cmd_code = 8'h0F;
    // R5 wrap: a zero interval reloads on every tick
    fi_value = 14'd0;
    for (int i = 0; i < 65560; i++) step(1);
    check(m_reload_seen && m_fn < 100, "R5 wrap reached", m_fn, 0);
    fi_value = 14'h3FFF;
    for (int i = 0; i < 20; i++) step(1);
    // R11 mid-run reset
    rst = 1'b1;
    step(0);
    @(negedge clk);
    check(remaining == 0 && frame_num == 0 && frame_toggle == 0, "R11 reset mid-run",
          {remaining, frame_num, frame_toggle}, 0);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) step(1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule